// File: doc/BRIEF.md
# Bus Transaction Coverage Monitor

A passive observer for a multiplexed address/data parallel bus with active-low framing, initiator-ready and target-ready strobes and a shared command/byte-enable field. It is meant to stay in a prototype for long runs on real hardware. Over such a run it records which bus commands appeared and how often each one did, along with the longest burst seen, measured in completed data phases. It also raises a sticky flag when the initiator-ready strobe is active outside any transaction.

All of its bus pins are inputs, so it never drives the bus. When the run ends, software or a debug path reads the statistics through a small address-indexed read port. A command that was never seen, or a burst ceiling that stayed low, shows where directed tests are still needed. A single-cycle clear input resets the statistics so that a new measurement window can begin.

Top module: `bus_cov_monitor`

## Requirements
- R1: A transaction begins on the first clock where `frame_ni` is sampled low while no transaction is open. The command is the raw 4-bit value of `cbe_ni` on that clock. Holding `frame_ni` low for later cycles does not start a second transaction.
- R2: Each command value has its own seen flag. The flag sets when a transaction with that command begins and stays set until a clear.
- R3: Each command value has its own counter, which goes up by one for every transaction that begins with that command.
- R4: A command counter that holds all-ones keeps that value and does not wrap.
- R5: A data phase is counted only on a clock inside an open transaction where `irdy_ni` and `trdy_ni` are both low. A cycle where only one of them is low does not count. The transaction closes on the first clock where `frame_ni` and `irdy_ni` are both high.
- R6: When a transaction closes, the burst maximum takes its data-phase count if that count is larger. A shorter burst never lowers the maximum.
- R7: The data-phase count of one burst saturates at all-ones of `BURST_W` bits, so the maximum is limited to that value.
- R8: One clock with `clear_i` high sets every seen flag, counter, the burst maximum and the error flag to zero. Clear takes priority over any update on the same clock.
- R9: `proto_err_o` sets on the clock after `irdy_ni` is sampled low with no transaction open, and stays high until a clear. Normal transactions never set it.
- R10: `rd_data_o` is a register that shows, one clock after `rd_addr_i` is sampled, the value at that address. Addresses 0 to 15 give the counter of the command with that value. Address 16 gives the seen flags, where bit i belongs to command i. Address 17 gives the burst maximum. Address 18 gives the error flag in bit 0. Every other address reads zero.
- R11: After reset every statistic reads zero and `proto_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Single-cycle clear of all statistics |
| frame_ni | input | 1 | Sampled framing strobe, active low |
| irdy_ni | input | 1 | Sampled initiator-ready strobe, active low |
| trdy_ni | input | 1 | Sampled target-ready strobe, active low |
| cbe_ni | input | CMD_W | Sampled command / byte-enable field |
| rd_addr_i | input | ADDR_W | Statistics read address |
| rd_data_o | output | DATA_W | Registered read data |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The in-line assertions check several properties on every cycle. Counters at all-ones stay there. Seen flags and the error flag, once set, stay set unless a clear arrives. The burst maximum never falls except on a clear, and a clear leaves zero behind. The burst length register changes only on a start or a counted data phase. Other behaviours need a model of the bus and can only be shown by the bench's scenarios: the command being taken from the address phase alone, wait-state cycles being left out of the burst length, the mapping of read addresses to statistics, and a zero-data-phase transaction being counted. The bench covers these with transactions of mixed length, wait states and commands, with enough repeats to saturate both counter types, and with a stray ready strobe.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} trk_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bcm_txn_tracker.sv
module bcm_txn_tracker
  import bcm_pkg::*;
#(
  parameter int CMD_W   = 4,
  parameter int BURST_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic               trdy_ni,
  input  logic [CMD_W-1:0]   cbe_ni,
  output logic               start_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic               done_o,
  output logic [BURST_W-1:0] len_o,
  output logic               err_o
);
  trk_state_e state_q, state_d;
  logic start, beat, finish, err_q;
  logic [BURST_W-1:0] len_q;

  assign start  = (state_q == ST_IDLE) && !frame_ni;
  assign beat   = (state_q == ST_BUSY) && !irdy_ni && !trdy_ni;
  assign finish = (state_q == ST_BUSY) && frame_ni && irdy_ni;

  always_comb begin
    state_d = state_q;
    if (start)       state_d = ST_BUSY;
    else if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) len_q <= '0;
      else if (beat && len_q != '1) len_q <= len_q + BURST_W'(1);
      if (clear_i) err_q <= 1'b0;
      else if (state_q == ST_IDLE && !irdy_ni) err_q <= 1'b1;
    end
  end

  assign start_o = start;
  assign cmd_o   = cbe_ni;
  assign done_o  = finish;
  assign len_o   = len_q;
  assign err_o   = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clear_i |=> err_q);
  // R1
  start_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> state_q == ST_BUSY);
  // R5
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start && !beat |=> $stable(len_q));
endmodule

// File: rtl/bcm_cmd_stats.sv
module bcm_cmd_stats #(
  parameter int CMD_W   = 4,
  parameter int CNT_W   = 16,
  parameter int NUM_CMD = 1 << CMD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     start_i,
  input  logic [CMD_W-1:0]         cmd_i,
  output logic [NUM_CMD*CNT_W-1:0] cnt_o,
  output logic [NUM_CMD-1:0]       seen_o
);
  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    logic hit, s_q;
    logic [CNT_W-1:0] c_q;

    assign hit = start_i && (cmd_i == CMD_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_q <= '0;
        s_q <= 1'b0;
      end else if (clear_i) begin
        c_q <= '0;
        s_q <= 1'b0;
      end else if (hit) begin
        s_q <= 1'b1;
        if (c_q != '1) c_q <= c_q + CNT_W'(1);
      end
    end

    assign cnt_o[g*CNT_W +: CNT_W] = c_q;
    assign seen_o[g] = s_q;

    // R4
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c_q == '1) && !clear_i |=> c_q == '1);
    // R2
    seen_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_q && !clear_i |=> s_q);
    // R8
    cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (c_q == '0) && !s_q);
  end
endmodule

// File: rtl/bcm_burst_max.sv
module bcm_burst_max #(
  parameter int BURST_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               done_i,
  input  logic [BURST_W-1:0] len_i,
  output logic [BURST_W-1:0] max_o
);
  logic [BURST_W-1:0] max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      max_q <= '0;
    else if (clear_i)                 max_q <= '0;
    else if (done_i && len_i > max_q) max_q <= len_i;
  end

  assign max_o = max_q;

  // R6
  max_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> max_q >= $past(max_q));
  // R6
  max_covers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !clear_i |=> max_q >= $past(len_i));
  // R8
  max_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> max_q == '0);
endmodule

// File: rtl/bcm_readout.sv
module bcm_readout #(
  parameter int CMD_W   = 4,
  parameter int CNT_W   = 16,
  parameter int BURST_W = 16,
  parameter int NUM_CMD = 16,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NUM_CMD*CNT_W-1:0] cnt_i,
  input  logic [NUM_CMD-1:0]       seen_i,
  input  logic [BURST_W-1:0]       max_i,
  input  logic                     err_i,
  output logic [DATA_W-1:0]        data_o
);
  localparam int A_SEEN = NUM_CMD;
  localparam int A_MAX  = NUM_CMD + 1;
  localparam int A_ERR  = NUM_CMD + 2;

  logic [CMD_W-1:0]  idx;
  logic [DATA_W-1:0] nxt, data_q;

  assign idx = addr_i[CMD_W-1:0];

  always_comb begin
    nxt = '0;
    if (addr_i < ADDR_W'(NUM_CMD))     nxt = DATA_W'(cnt_i[idx*CNT_W +: CNT_W]);
    else if (addr_i == ADDR_W'(A_SEEN)) nxt = DATA_W'(seen_i);
    else if (addr_i == ADDR_W'(A_MAX))  nxt = DATA_W'(max_i);
    else if (addr_i == ADDR_W'(A_ERR))  nxt = DATA_W'(err_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= nxt;
  end

  assign data_o = data_q;
endmodule

// File: rtl/bus_cov_monitor.sv
module bus_cov_monitor
  import bcm_pkg::*;
#(
  parameter int CMD_W   = 4,
  parameter int CNT_W   = 16,
  parameter int BURST_W = 16,
  localparam int NUM_CMD = 1 << CMD_W,
  localparam int ADDR_W  = $clog2(NUM_CMD + 3),
  localparam int DATA_W  = imax(imax(CNT_W, BURST_W), NUM_CMD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic              trdy_ni,
  input  logic [CMD_W-1:0]  cbe_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              proto_err_o
);
  logic                     start, done, err;
  logic [CMD_W-1:0]         cmd;
  logic [BURST_W-1:0]       len, max_len;
  logic [NUM_CMD*CNT_W-1:0] cnt;
  logic [NUM_CMD-1:0]       seen;

  bcm_txn_tracker #(.CMD_W(CMD_W), .BURST_W(BURST_W)) u_trk (
    .clk_i, .rst_ni, .clear_i, .frame_ni, .irdy_ni, .trdy_ni, .cbe_ni,
    .start_o(start), .cmd_o(cmd), .done_o(done), .len_o(len), .err_o(err)
  );

  bcm_cmd_stats #(.CMD_W(CMD_W), .CNT_W(CNT_W), .NUM_CMD(NUM_CMD)) u_stats (
    .clk_i, .rst_ni, .clear_i, .start_i(start), .cmd_i(cmd),
    .cnt_o(cnt), .seen_o(seen)
  );

  bcm_burst_max #(.BURST_W(BURST_W)) u_max (
    .clk_i, .rst_ni, .clear_i, .done_i(done), .len_i(len), .max_o(max_len)
  );

  bcm_readout #(
    .CMD_W(CMD_W), .CNT_W(CNT_W), .BURST_W(BURST_W),
    .NUM_CMD(NUM_CMD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk_i, .rst_ni, .addr_i(rd_addr_i), .cnt_i(cnt), .seen_i(seen),
    .max_i(max_len), .err_i(err), .data_o(rd_data_o)
  );

  assign proto_err_o = err;
endmodule

// File: tb/tb_bus_cov_monitor.sv
module tb_bus_cov_monitor;
  localparam int CNT_W = 4;
  localparam int BW    = 4;
  localparam int SAT   = 15;
  localparam int A_SEEN = 16, A_MAX = 17, A_ERR = 18;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [3:0]  cbe = 4'h0;
  logic [4:0]  rd_addr = 5'd0;
  logic [15:0] rd_data;
  logic        perr;

  int errs = 0, checks = 0;
  int exp_cnt [16];
  int exp_seen = 0, exp_max = 0, exp_err = 0;

  int    exp_q [$];
  string tag_q [$];
  logic  rd_v = 1'b0, rd_v_q = 1'b0;

  always #2 clk = ~clk;

  bus_cov_monitor #(.CMD_W(4), .CNT_W(CNT_W), .BURST_W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .frame_ni(frame_n),
    .irdy_ni(irdy_n), .trdy_ni(trdy_n), .cbe_ni(cbe), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .proto_err_o(perr)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_v_q <= rd_v;
  always @(negedge clk) begin
    if (rd_v_q && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(int'(rd_data), e, t);
    end
  end

  // driver: issue a read and push its expected value
  task automatic rd(input int a, input int exp, input string tag);
    rd_addr = 5'(a);
    rd_v = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 16; i++) rd(i, exp_cnt[i], tag);
    rd(A_SEEN, exp_seen, tag);
    rd(A_MAX, exp_max, tag);
    rd(A_ERR, exp_err, tag);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_txn(input logic [3:0] cmd, input int n, input int w);
    frame_n = 1'b0; cbe = cmd; irdy_n = 1'b1; trdy_n = 1'b1;
    if (exp_cnt[cmd] < SAT) exp_cnt[cmd]++;
    exp_seen = exp_seen | (1 << cmd);
    if (((n > SAT) ? SAT : n) > exp_max) exp_max = (n > SAT) ? SAT : n;
    @(negedge clk);
    cbe = 4'h0;
    if (n == 0) begin
      frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b1;
      @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      frame_n = (i == n - 1);
      for (int k = 0; k < w; k++) begin
        irdy_n = 1'b0; trdy_n = 1'b1;
        @(negedge clk);
      end
      irdy_n = 1'b0; trdy_n = 1'b0;
      @(negedge clk);
    end
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(int'(perr), 0, "R11");
    rd_all("R11");
    drain();

    // R1 R3 R5: mixed bursts, wait states not counted
    bus_txn(4'h6, 3, 0);
    bus_txn(4'h7, 1, 2);
    bus_txn(4'h6, 5, 1);
    rd(6, 2, "R3");
    rd(7, 1, "R1");
    rd(A_MAX, 5, "R5");
    rd(A_SEEN, exp_seen, "R2");
    drain();

    // R6 shorter burst keeps max; zero-data-phase transaction counted
    bus_txn(4'h2, 2, 0);
    bus_txn(4'hC, 0, 0);
    rd(A_MAX, 5, "R6");
    rd(12, 1, "R3");
    rd(2, 1, "R3");
    chk(int'(perr), 0, "R9");
    drain();

    // R4 counter saturation
    for (int i = 0; i < 17; i++) bus_txn(4'hA, 1, 0);
    rd(10, SAT, "R4");
    // R7 burst length saturation
    bus_txn(4'h3, 20, 0);
    rd(A_MAX, SAT, "R7");
    // R10 unused address and full map
    rd(25, 0, "R10");
    rd(31, 0, "R10");
    rd_all("R10");
    drain();

    // R9 stray ready strobe
    irdy_n = 1'b0;
    @(negedge clk);
    irdy_n = 1'b1;
    exp_err = 1;
    chk(int'(perr), 1, "R9");
    @(negedge clk);
    chk(int'(perr), 1, "R9");
    rd(A_ERR, 1, "R9");
    drain();

    // R8 single-cycle clear
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    foreach (exp_cnt[i]) exp_cnt[i] = 0;
    exp_seen = 0; exp_max = 0; exp_err = 0;
    chk(int'(perr), 0, "R8");
    rd_all("R8");
    drain();

    // R1 counting resumes after clear
    bus_txn(4'h3, 2, 0);
    rd(3, 1, "R1");
    rd(A_SEEN, 1 << 3, "R2");
    rd(A_MAX, 2, "R6");
    drain();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule